// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block holds sixteen event-pending flags and sixteen matching mask bits behind a small I/O-mapped window, and drives a level-sensitive system control interrupt (SCI). Hardware event sources pulse their inputs, and the block latches each rising edge into a pending flag. Host software finds the cause by reading the flags, masks or unmasks sources through the mask bits, and acknowledges an event by writing a one to its flag.

The host reaches the window through a simple one-cycle request port that carries a start address, a byte count from 1 to 4 and up to four data bytes. Each byte lane of a request is decoded on its own at address start+lane, in little-endian order. This means an access may cover the window only in part. Read data comes back on the cycle after the request. The interrupt line is derived from registered state, so it follows any write or event on the next cycle.

Top module: `gpe_event_block`

## Requirements
- R1: The window is the 4 bytes at I/O addresses 0xAFE0 to 0xAFE3. Offset 0 holds pending flags 7:0, offset 1 holds pending flags 15:8, offset 2 holds mask bits 7:0 and offset 3 holds mask bits 15:8.
- R2: A read request (bus_sel=1, bus_we=0) raises bus_rvalid on the next cycle. In the same cycle, bus_rdata byte lane i holds the byte at address bus_addr+i. Lanes i >= bus_len read 0x00.
- R3: An active lane whose address lies outside the window reads 0xFF. A write lane outside the window changes nothing.
- R4: Pending flags are write-one-to-clear. A written 1 clears the flag and a written 0 leaves it unchanged.
- R5: Mask bits are plain read/write storage.
- R6: A low-to-high transition on evt_in[k] sets pending flag k on that clock edge. An input held high does not set the flag again after it has been cleared.
- R7: When an edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: sci is high exactly while some pending flag and its mask bit are both 1. It reflects a write or an event one cycle after the request or edge.
- R9: Reset (rst_n low, asynchronous) clears all flags and mask bits, and drives sci and bus_rvalid low.
- R10: A request that straddles a window edge takes effect on its in-window lanes only. Its out-of-window lanes read 0xFF and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | I/O address of byte lane 0 |
| bus_len | input | 3 | Number of bytes in the request, 1 to 4 |
| bus_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| evt_in | input | 16 | Hardware event inputs, edge detected |
| sci | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the following: an event edge leaves its flag set, including against a simultaneous clear; a clear without an edge leaves the flag at zero; mask bits stay stable when no mask byte is written; inactive and out-of-window lanes return 0x00 and 0xFF; and sci is never high with all mask bits clear. Some behaviour only the bench scenarios can show. This covers the byte placement of flags and masks within the window, little-endian lane order across a straddling access, the sticky effect of a held-high input after a clear, and the return of sci to low once a write masks the pending source. The bench's reference model covers these cases cycle by cycle.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  typedef logic [7:0] gpe_byte_t;

  // True when address a falls inside [base, base+nbytes)
  function automatic logic addr_in_window(input logic [31:0] a,
                                          input logic [31:0] base,
                                          input logic [31:0] nbytes);
    return (a >= base) && (a < base + nbytes);
  endfunction

  // True when lane index is below the requested byte count
  function automatic logic lane_used(input int lane, input int len);
    return len > lane;
  endfunction
endpackage

// File: rtl/gpe_lane_decode.sv
module gpe_lane_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0,
  parameter int WIN_BYTES = 4,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                        sel,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LEN_W-1:0]            len,
  output logic [LANES-1:0]            lane_act,
  output logic [LANES-1:0]            lane_hit,
  output logic [LANES-1:0][OFF_W-1:0] lane_off
);
  import gpe_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [ADDR_W-1:0] rel;
    assign lane_addr   = addr + ADDR_W'(i);
    assign rel         = lane_addr - BASE_ADDR;
    assign lane_act[i] = sel && lane_used(i, int'(len));
    assign lane_hit[i] = lane_act[i] &&
                         addr_in_window(32'(lane_addr), 32'(BASE_ADDR), 32'(WIN_BYTES));
    assign lane_off[i] = rel[OFF_W-1:0];
  end
endmodule

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
  parameter int NUM_EVT = 16,
  parameter int LANES = 4,
  localparam int ST_BYTES = NUM_EVT / 8,
  localparam int WIN_BYTES = 2 * ST_BYTES,
  localparam int OFF_W = $clog2(WIN_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            lane_wr,
  input  logic [LANES-1:0][OFF_W-1:0] lane_off,
  input  logic [8*LANES-1:0]          wdata,
  input  logic [NUM_EVT-1:0]          evt_in,
  output logic [NUM_EVT-1:0]          sts_q,
  output logic [NUM_EVT-1:0]          en_q
);
  logic [NUM_EVT-1:0]   evt_q;
  logic [NUM_EVT-1:0]   evt_rise;
  logic [NUM_EVT-1:0]   clr_mask;
  logic [NUM_EVT-1:0]   en_wr;
  logic [NUM_EVT-1:0]   en_wval;
  logic [WIN_BYTES-1:0] byte_sel;
  logic [WIN_BYTES-1:0][7:0] byte_val;

  assign evt_rise = evt_in & ~evt_q;

  // Route each written lane to the window byte it addresses
  always_comb begin
    byte_sel = '0;
    byte_val = '0;
    for (int b = 0; b < WIN_BYTES; b++) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_wr[i] && lane_off[i] == OFF_W'(b)) begin
          byte_sel[b] = 1'b1;
          byte_val[b] = wdata[8*i +: 8];
        end
      end
    end
  end

  for (genvar b = 0; b < ST_BYTES; b++) begin : g_byte
    assign clr_mask[8*b +: 8] = byte_sel[b] ? byte_val[b] : 8'h00;
    assign en_wr[8*b +: 8]    = {8{byte_sel[ST_BYTES + b]}};
    assign en_wval[8*b +: 8]  = byte_val[ST_BYTES + b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= evt_in;
      sts_q <= (sts_q & ~clr_mask) | evt_rise;
      en_q  <= (en_q & ~en_wr) | (en_wval & en_wr);
    end
  end

  // R6: an edge leaves its flag set
  a_r6_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_rise) |=> ((sts_q & $past(evt_rise)) == $past(evt_rise)));
  // R7: edge beats a same-cycle clear
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_rise & clr_mask)) |=>
      ((sts_q & $past(evt_rise & clr_mask)) == $past(evt_rise & clr_mask)));
  // R4: a clear without an edge empties the flag
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~evt_rise)) |=> ((sts_q & $past(clr_mask & ~evt_rise)) == '0));
  // R5: mask bits hold without a mask write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr == '0) |=> $stable(en_q));
endmodule

// File: rtl/gpe_readback.sv
module gpe_readback #(
  parameter int WIN_BYTES = 4,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(WIN_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [LANES-1:0]            lane_act,
  input  logic [LANES-1:0]            lane_hit,
  input  logic [LANES-1:0][OFF_W-1:0] lane_off,
  input  logic [8*WIN_BYTES-1:0]      win_vec,
  output logic [8*LANES-1:0]          rdata,
  output logic                        rvalid
);
  import gpe_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_req;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gpe_byte_t lane_byte;
    always_comb begin
      if (!lane_act[i])     lane_byte = 8'h00;
      else if (lane_hit[i]) lane_byte = win_vec[{lane_off[i], 3'b000} +: 8];
      else                  lane_byte = 8'hFF;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[8*i +: 8] <= 8'h00;
      else if (rd_req) rdata[8*i +: 8] <= lane_byte;
    end

    // R3: outside lanes read all ones
    a_r3_outside_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lane_act[i] && !lane_hit[i]) |=> (rdata[8*i +: 8] == 8'hFF));
    // R2: lanes beyond the count read zero
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !lane_act[i]) |=> (rdata[8*i +: 8] == 8'h00));
  end

  // R2: valid only after a read request
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_req));
endmodule

// File: rtl/gpe_event_block.sv
module gpe_event_block #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0,
  parameter int NUM_EVT = 16,
  parameter int LANES = 4,
  localparam int WIN_BYTES = 2 * (NUM_EVT / 8),
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [LEN_W-1:0]     bus_len,
  input  logic [8*LANES-1:0]   bus_wdata,
  output logic [8*LANES-1:0]   bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_EVT-1:0]   evt_in,
  output logic                 sci
);
  logic [LANES-1:0]            lane_act;
  logic [LANES-1:0]            lane_hit;
  logic [LANES-1:0][OFF_W-1:0] lane_off;
  logic [LANES-1:0]            lane_wr;
  logic                        rd_req;
  logic [NUM_EVT-1:0]          sts_q;
  logic [NUM_EVT-1:0]          en_q;

  assign lane_wr = lane_hit & {LANES{bus_we}};
  assign rd_req  = bus_sel & ~bus_we;

  gpe_lane_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES), .LANES(LANES)
  ) u_decode (
    .sel(bus_sel), .addr(bus_addr), .len(bus_len),
    .lane_act(lane_act), .lane_hit(lane_hit), .lane_off(lane_off)
  );

  gpe_event_regs #(.NUM_EVT(NUM_EVT), .LANES(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .lane_off(lane_off),
    .wdata(bus_wdata), .evt_in(evt_in), .sts_q(sts_q), .en_q(en_q)
  );

  gpe_readback #(.WIN_BYTES(WIN_BYTES), .LANES(LANES)) u_readback (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .lane_act(lane_act),
    .lane_hit(lane_hit), .lane_off(lane_off), .win_vec({en_q, sts_q}),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign sci = |(sts_q & en_q);

  // R8: interrupt needs a mask bit and a pending flag
  a_r8_sci_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> ((|en_q) && (|sts_q)));
  // R9: quiet outputs out of reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sci && !bus_rvalid));
endmodule

// File: tb/tb_gpe_event_block.sv
`timescale 1ns/100ps
module tb_gpe_event_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [2:0]  bus_len = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] evt_in = '0;
  logic        sci;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpe_event_block dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .evt_in(evt_in), .sci(sci)
  );

  // Behavioural reference model
  int unsigned m_sts = 0, m_en = 0, m_prev = 0, m_rdata = 0;
  bit m_rvalid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_prev = 0; m_rdata = 0; m_rvalid = 0;
    end else begin
      int unsigned rise, clr;
      rise = evt_in & ~m_prev;
      clr = 0;
      m_rvalid = bus_sel && !bus_we;
      if (bus_sel && !bus_we) begin
        m_rdata = 0;
        for (int i = 0; i < 4; i++) begin
          int a, b;
          a = int'(bus_addr) + i;
          if (i < int'(bus_len)) begin
            if (a >= 'hAFE0 && a <= 'hAFE3) begin
              b = a - 'hAFE0;
              if (b < 2) m_rdata |= ((m_sts >> (8*b)) & 'hFF) << (8*i);
              else       m_rdata |= ((m_en >> (8*(b-2))) & 'hFF) << (8*i);
            end else m_rdata |= 'hFF << (8*i);
          end
        end
      end
      if (bus_sel && bus_we) begin
        for (int i = 0; i < 4; i++) begin
          int a, b;
          int unsigned v;
          a = int'(bus_addr) + i;
          v = (bus_wdata >> (8*i)) & 'hFF;
          if (i < int'(bus_len) && a >= 'hAFE0 && a <= 'hAFE3) begin
            b = a - 'hAFE0;
            if (b < 2) clr |= v << (8*b);
            else m_en = (m_en & ~('hFF << (8*(b-2)))) | (v << (8*(b-2)));
          end
        end
      end
      m_sts = ((m_sts & ~clr) | rise) & 'hFFFF;
      m_prev = evt_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 sci vs model", {31'b0, sci}, {31'b0, ((m_sts & m_en) != 0)});
      chk("R2 rvalid vs model", {31'b0, bus_rvalid}, {31'b0, m_rvalid});
      if (m_rvalid) chk("R2 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic bus_op(input bit we, input logic [15:0] a, input logic [2:0] n,
                        input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_len = n; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [2:0] n,
                        input logic [31:0] exp, input string tag);
    bus_op(0, a, n, 0);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt_in[k] = 1;
    @(negedge clk); evt_in[k] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 sci low in reset", {31'b0, sci}, 0);
    rst_n = 1;
    rd_chk(16'hAFE0, 4, 32'h0, "R9 window clear after reset");
    // R5 / R1: mask bytes at offsets 2 and 3
    bus_op(1, 16'hAFE2, 2, 32'h0000_00A5);
    rd_chk(16'hAFE0, 4, 32'h00A5_0000, "R1 R5 mask placement");
    // R6 / R8: masked-in event raises sci
    pulse(0);
    rd_chk(16'hAFE0, 2, 32'h0000_0001, "R6 edge sets flag 0");
    chk("R8 sci with enabled flag", {31'b0, sci}, 1);
    pulse(1);
    rd_chk(16'hAFE0, 2, 32'h0000_0003, "R6 edge sets flag 1");
    // R4: write-one-to-clear, sci drops next cycle
    bus_op(1, 16'hAFE0, 1, 32'h0000_0001);
    chk("R8 sci drops after clear", {31'b0, sci}, 0);
    rd_chk(16'hAFE0, 2, 32'h0000_0002, "R4 clear flag 0");
    bus_op(1, 16'hAFE0, 2, 32'h0000_0000);
    rd_chk(16'hAFE0, 2, 32'h0000_0002, "R4 zero write keeps flags");
    // R7: edge and clear in the same cycle
    pulse(4);
    @(negedge clk);
    evt_in[4] = 1; bus_sel = 1; bus_we = 1; bus_addr = 16'hAFE0; bus_len = 1;
    bus_wdata = 32'h10;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    rd_chk(16'hAFE0, 1, 32'h0000_0012, "R7 set beats clear");
    // R6: held-high input does not set again
    bus_op(1, 16'hAFE0, 1, 32'h0000_0010);
    rd_chk(16'hAFE0, 1, 32'h0000_0002, "R6 held input no re-set");
    evt_in[4] = 0;
    // R10 / R3: straddling and outside reads
    rd_chk(16'hAFDE, 4, 32'h0002_FFFF, "R10 straddling read");
    rd_chk(16'h1234, 1, 32'h0000_00FF, "R3 outside read FF, R2 unused lanes 00");
    bus_op(1, 16'h1234, 4, 32'hFFFF_FFFF);
    rd_chk(16'hAFE0, 4, 32'h00A5_0002, "R3 outside write ignored");
    bus_op(1, 16'hAFE3, 2, 32'h0000_5A80);
    rd_chk(16'hAFE2, 2, 32'h0000_80A5, "R10 straddling write");
    // R8: high event with mask, then mask cleared
    pulse(15);
    chk("R8 sci on flag 15", {31'b0, sci}, 1);
    rd_chk(16'hAFE0, 2, 32'h0000_8002, "R6 edge sets flag 15");
    bus_op(1, 16'hAFE2, 2, 32'h0);
    chk("R8 sci drops when masked", {31'b0, sci}, 0);
    // R9: reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R9 sci low during reset", {31'b0, sci}, 0);
    chk("R9 rvalid low during reset", {31'b0, bus_rvalid}, 0);
    rst_n = 1;
    rd_chk(16'hAFE0, 4, 32'h0, "R9 state cleared by reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule